// File: doc/BRIEF.md
# CAN Identifier Arbitration Unit

This block takes part in the bitwise contest that decides which node owns a CAN bus at the start of a frame. After a start-of-frame sync pulse, it drives the frame's arbitration bits onto the transmit line one at a time. The order is the start bit, then the identifier from its most significant bit down, then the format bits. At every sample-point strobe it compares the level it is driving with the level on the receive line.

The bus acts as a wired AND, with 0 dominant and 1 recessive. A node that drives recessive but reads dominant has met a lower identifier. That node backs off to recessive and only listens for the rest of the frame. It also reports the bit position where it lost. A node that drives dominant but reads recessive has a fault, and it reports a bit error instead. A node that reaches the end of the field with no mismatch has won the bus.

A bit-timing unit outside this block supplies the sample-point and bit-advance strobes. Stuffing, the data phase and the CRC are handled elsewhere.

Top module: `can_arb_unit`

## Requirements
- R1: After reset, tx is 1 (recessive) and arb_won, arb_lost and bit_err are all 0.
- R2: In the cycle after sof_sync, tx is 0 (the dominant start bit, position 0) and all three result flags are 0. The identifier and format inputs are captured on that pulse.
- R3: A standard frame (tx_ext=0) has 13 positions. Position 0 is the start bit 0. Positions 1..11 carry tx_id[10:0], most significant bit first. Position 12 carries tx_rtr.
- R4: An extended frame (tx_ext=1) has 33 positions. Position 0 is the start bit 0. Positions 1..11 carry tx_id[28:18], most significant bit first. Positions 12 and 13 are both 1. Positions 14..31 carry tx_id[17:0], most significant bit first. Position 32 carries tx_rtr.
- R5: tx changes only in the cycle after a sof_sync, sample_stb or advance_stb. Each position is held until advance_stb moves to the next one.
- R6: When rx equals tx at a sample_stb, the block carries on and sends the next position at the following advance_stb.
- R7: When tx is 1 and rx is 0 at a sample_stb, arb_lost rises in the next cycle and lost_pos holds the current position. tx then stays 1 until the next sof_sync.
- R8: When tx is 0 and rx is 1 at a sample_stb, bit_err rises in the next cycle, arb_lost stays 0, and tx stays 1 until the next sof_sync.
- R9: An advance_stb at the last position with no mismatch raises arb_won in the next cycle. tx is then 1.
- R10: At most one of arb_won, arb_lost and bit_err is 1 at a time. Each one, and lost_pos, holds until the next sof_sync clears it.
- R11: sample_stb and advance_stb have no effect outside an active field: before the first sof_sync, and after a result is reached.
- R12: When two nodes contend, the one with the numerically lower arbitration field keeps the bus and the other one loses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sof_sync | input | 1 | Frame sync pulse; starts a new arbitration field |
| sample_stb | input | 1 | Sample-point strobe; rx is compared with tx |
| advance_stb | input | 1 | Bit-advance strobe; moves to the next position |
| tx_id | input | 29 | Identifier to send (standard frames use bits 10:0) |
| tx_ext | input | 1 | 1 selects the extended format |
| tx_rtr | input | 1 | Level sent in the final (remote request) position |
| rx | input | 1 | Bus level read back from the transceiver |
| tx | output | 1 | Transmit line, 0 dominant |
| arb_won | output | 1 | Field completed with no mismatch |
| arb_lost | output | 1 | Lost to a dominant bit |
| lost_pos | output | 6 | Position where arbitration was lost |
| bit_err | output | 1 | Dominant sent but recessive read |

## Verification
The bench models a second node on a wired-AND bus and contends at the points that matter most. These are adjacent identifiers, an extended frame against a standard frame with the same base identifier (the loss falls on the substitute bit at position 12), and a data frame against a remote frame that loses on the final bit. A unit that sends the identifier least significant bit first, or that puts the format bits in the wrong place, loses at the wrong position or wins when it should lose. A forced recessive level on a dominant bit, both on the start bit and mid-field, must give a bit error and not a loss. A design that mixes up the two cases reports the wrong flag. Strobes sent while the unit is idle or finished must leave tx and the flags untouched. A design that keeps counting would move lost_pos or drive the bus again.

// File: rtl/can_arb_pkg.sv
// Shared constants and types for the CAN arbitration unit.
// Assumes the classic frame layout: 11 base identifier bits and 18 extension bits.
package can_arb_pkg;
    localparam int BASE_ID_BITS = 11;
    localparam int EXT_ID_BITS  = 18;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_RUN,
        ARB_WON,
        ARB_LOST,
        ARB_BITERR
    } arb_state_e;

    typedef enum logic [1:0] {
        CMP_MATCH,
        CMP_LOST,
        CMP_BITERR
    } cmp_verdict_e;
endpackage

// File: rtl/can_arb_field.sv
// Builds the arbitration field as a vector indexed by position (0 = start bit).
// Assumes: the identifier is right aligned, with the standard identifier in the
// low BASE_W bits. Unused positions of a standard frame are padded recessive.
module can_arb_field #(
    parameter int BASE_W = 11,
    parameter int EXT_W  = 18,
    localparam int ID_W  = BASE_W + EXT_W,
    localparam int FLD_W = BASE_W + EXT_W + 4,
    localparam int POS_W = $clog2(FLD_W)
) (
    input  logic [ID_W-1:0]  id,
    input  logic             ext,
    input  logic             rtr,
    output logic [FLD_W-1:0] field,
    output logic [POS_W-1:0] last_pos
);
    localparam int STD_LAST = BASE_W + 1;
    localparam int EXT_LAST = FLD_W - 1;

    logic [FLD_W-1:0] std_vec;
    logic [FLD_W-1:0] ext_vec;

    // Start bits and the base identifier, MSB first, for both formats.
    assign std_vec[0] = 1'b0;
    assign ext_vec[0] = 1'b0;
    for (genvar i = 0; i < BASE_W; i++) begin : g_base
        assign std_vec[1+i] = id[BASE_W-1-i];
        assign ext_vec[1+i] = id[ID_W-1-i];
    end

    // Standard tail: remote bit, then recessive padding.
    assign std_vec[STD_LAST] = rtr;
    for (genvar k = STD_LAST + 1; k < FLD_W; k++) begin : g_pad
        assign std_vec[k] = 1'b1;
    end

    // Extended tail: two recessive format bits, extension bits, remote bit.
    assign ext_vec[BASE_W+1] = 1'b1;
    assign ext_vec[BASE_W+2] = 1'b1;
    for (genvar j = 0; j < EXT_W; j++) begin : g_ext
        assign ext_vec[BASE_W+3+j] = id[EXT_W-1-j];
    end
    assign ext_vec[EXT_LAST] = rtr;

    // Select the format.
    always_comb begin
        field    = ext ? ext_vec : std_vec;
        last_pos = ext ? POS_W'(EXT_LAST) : POS_W'(STD_LAST);
    end
endmodule

// File: rtl/can_arb_judge.sv
// Compares the driven level with the level read back at a sample point.
// Assumes a wired-AND bus with 0 dominant.
module can_arb_judge
    import can_arb_pkg::*;
(
    input  logic         driven,
    input  logic         sensed,
    output cmp_verdict_e verdict
);
    // Classify the pair of levels.
    always_comb begin
        if (driven == sensed)
            verdict = CMP_MATCH;
        else if (driven)
            verdict = CMP_LOST;
        else
            verdict = CMP_BITERR;
    end
endmodule

// File: rtl/can_arb_ctrl.sv
// Sequencer: captures the field at sync, steps through the positions on the
// advance strobes, and settles on won, lost or bit error.
// Assumes the strobes are one cycle wide. A sample in the same cycle as an
// advance is judged first, and a sync overrides both.
module can_arb_ctrl
    import can_arb_pkg::*;
#(
    parameter int FLD_W = 33,
    localparam int POS_W = $clog2(FLD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_sync,
    input  logic             sample_stb,
    input  logic             advance_stb,
    input  logic [FLD_W-1:0] field_in,
    input  logic [POS_W-1:0] last_in,
    input  cmp_verdict_e     verdict,
    output logic             drive_bit,
    output logic             in_arb,
    output logic [POS_W-1:0] bit_pos,
    output logic [POS_W-1:0] lost_pos,
    output arb_state_e       state
);
    logic [FLD_W-1:0] field_q;
    logic [POS_W-1:0] last_q;

    // State, position counter and captured field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ARB_IDLE;
            bit_pos  <= '0;
            field_q  <= '1;
            last_q   <= '0;
            lost_pos <= '0;
        end else if (sof_sync) begin
            state    <= ARB_RUN;
            bit_pos  <= '0;
            field_q  <= field_in;
            last_q   <= last_in;
            lost_pos <= '0;
        end else if (state == ARB_RUN) begin
            if (sample_stb && verdict == CMP_LOST) begin
                state    <= ARB_LOST;
                lost_pos <= bit_pos;
            end else if (sample_stb && verdict == CMP_BITERR) begin
                state <= ARB_BITERR;
            end else if (advance_stb) begin
                if (bit_pos == last_q)
                    state <= ARB_WON;
                else
                    bit_pos <= bit_pos + 1'b1;
            end
        end
    end

    // Drive the current field bit while contending, otherwise release.
    always_comb begin
        in_arb    = (state == ARB_RUN);
        drive_bit = in_arb ? field_q[bit_pos] : 1'b1;
    end
endmodule

// File: rtl/can_arb_unit.sv
// Top level of the CAN arbitration unit: field builder, level judge and
// sequencer. tx is recessive whenever the unit is not contending.
// Assumes rx is already synchronised to clk.
module can_arb_unit
    import can_arb_pkg::*;
#(
    parameter int BASE_W = BASE_ID_BITS,
    parameter int EXT_W  = EXT_ID_BITS,
    localparam int ID_W  = BASE_W + EXT_W,
    localparam int FLD_W = BASE_W + EXT_W + 4,
    localparam int POS_W = $clog2(FLD_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_sync,
    input  logic            sample_stb,
    input  logic            advance_stb,
    input  logic [ID_W-1:0] tx_id,
    input  logic            tx_ext,
    input  logic            tx_rtr,
    input  logic            rx,
    output logic            tx,
    output logic            arb_won,
    output logic            arb_lost,
    output logic [POS_W-1:0] lost_pos,
    output logic            bit_err
);
    logic [FLD_W-1:0] field_w;
    logic [POS_W-1:0] last_w;
    logic             drive_bit;
    logic             in_arb;
    logic [POS_W-1:0] bit_pos;
    cmp_verdict_e     verdict;
    arb_state_e       state;

    can_arb_field #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_field (
        .id       (tx_id),
        .ext      (tx_ext),
        .rtr      (tx_rtr),
        .field    (field_w),
        .last_pos (last_w)
    );

    can_arb_judge u_judge (
        .driven  (drive_bit),
        .sensed  (rx),
        .verdict (verdict)
    );

    can_arb_ctrl #(.FLD_W(FLD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_sync    (sof_sync),
        .sample_stb  (sample_stb),
        .advance_stb (advance_stb),
        .field_in    (field_w),
        .last_in     (last_w),
        .verdict     (verdict),
        .drive_bit   (drive_bit),
        .in_arb      (in_arb),
        .bit_pos     (bit_pos),
        .lost_pos    (lost_pos),
        .state       (state)
    );

    // Decode the result flags from the settled state.
    always_comb begin
        tx       = drive_bit;
        arb_won  = (state == ARB_WON);
        arb_lost = (state == ARB_LOST);
        bit_err  = (state == ARB_BITERR);
    end
endmodule

// File: rtl/can_arb_unit_chk.sv
// Protocol checker for can_arb_unit, attached through bind.
// Assumes it sees the top-level ports plus the in_arb and bit_pos nets.
module can_arb_unit_chk #(
    parameter int POS_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof_sync,
    input logic             sample_stb,
    input logic             advance_stb,
    input logic             rx,
    input logic             tx,
    input logic             arb_won,
    input logic             arb_lost,
    input logic [POS_W-1:0] lost_pos,
    input logic             bit_err,
    input logic             in_arb,
    input logic [POS_W-1:0] bit_pos
);
    assert_start_dominant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_sync |=> (!tx && !arb_won && !arb_lost && !bit_err));

    assert_tx_moves_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx) |-> ($past(sof_sync) || $past(sample_stb) || $past(advance_stb)));

    assert_loss_detected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_arb && sample_stb && !sof_sync && tx && !rx) |=> (arb_lost && lost_pos == $past(bit_pos)));

    assert_bit_error_detected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_arb && sample_stb && !sof_sync && !tx && rx) |=> (bit_err && !arb_lost));

    assert_released_after_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_won || arb_lost || bit_err) |-> tx);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({arb_won, arb_lost, bit_err}) <= 1);

    assert_loss_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !sof_sync) |=> (arb_lost && $stable(lost_pos)));
endmodule

bind can_arb_unit can_arb_unit_chk #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_sync    (sof_sync),
    .sample_stb  (sample_stb),
    .advance_stb (advance_stb),
    .rx          (rx),
    .tx          (tx),
    .arb_won     (arb_won),
    .arb_lost    (arb_lost),
    .lost_pos    (lost_pos),
    .bit_err     (bit_err),
    .in_arb      (in_arb),
    .bit_pos     (bit_pos)
);

// File: tb/can_arb_unit_test.sv
module can_arb_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_sync = 1'b0;
    logic        sample_stb = 1'b0;
    logic        advance_stb = 1'b0;
    logic [28:0] tx_id = '0;
    logic        tx_ext = 1'b0;
    logic        tx_rtr = 1'b0;
    logic        rx;
    logic        tx;
    logic        arb_won, arb_lost, bit_err;
    logic [5:0]  lost_pos;
    logic        other_bit = 1'b1;
    logic        force_rec = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    // Wired-AND bus with a second node; force_rec models a stuck-recessive fault.
    assign rx = force_rec ? 1'b1 : (tx & other_bit);

    can_arb_unit uut (
        .clk(clk), .rst_n(rst_n), .sof_sync(sof_sync), .sample_stb(sample_stb),
        .advance_stb(advance_stb), .tx_id(tx_id), .tx_ext(tx_ext), .tx_rtr(tx_rtr),
        .rx(rx), .tx(tx), .arb_won(arb_won), .arb_lost(arb_lost),
        .lost_pos(lost_pos), .bit_err(bit_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Field as defined in R3/R4; bit p is position p, unused positions recessive.
    function automatic logic [32:0] ref_field(input logic [28:0] id, input logic ext,
                                              input logic rtr);
        logic [32:0] v = '1;
        v[0] = 1'b0;
        if (ext) begin
            for (int i = 0; i < 11; i++) v[1+i] = id[28-i];
            v[12] = 1'b1;
            v[13] = 1'b1;
            for (int j = 0; j < 18; j++) v[14+j] = id[17-j];
            v[32] = rtr;
        end else begin
            for (int i = 0; i < 11; i++) v[1+i] = id[10-i];
            v[12] = rtr;
        end
        return v;
    endfunction

    // Runs one field against a rival pattern; checks tx, hold, and the result.
    task automatic run_frame(input string req, input logic [28:0] id, input logic ext,
                             input logic rtr, input logic [32:0] rival, input int fault_pos);
        logic [32:0] mine = ref_field(id, ext, rtr);
        int len = ext ? 33 : 13;
        bit done = 0;
        bit e_lost = 0, e_err = 0;
        int e_pos = 0;
        int tx_bad = 0, hold_bad = 0;
        tx_id = id; tx_ext = ext; tx_rtr = rtr;
        @(negedge clk) sof_sync = 1'b1;
        @(negedge clk) sof_sync = 1'b0;
        check(tx == 1'b0 && !arb_won && !arb_lost && !bit_err, "R2", "start bit and clear flags",
              int'(tx), 0);
        for (int p = 0; p < len; p++) begin
            logic exp_tx = done ? 1'b1 : mine[p];
            logic bus;
            if (tx !== exp_tx) tx_bad++;
            other_bit = rival[p];
            force_rec = (p == fault_pos);
            bus = force_rec ? 1'b1 : (exp_tx & rival[p]);
            if (!done && exp_tx && !bus) begin done = 1; e_lost = 1; e_pos = p; end
            else if (!done && !exp_tx && bus) begin done = 1; e_err = 1; end
            sample_stb = 1'b1;
            @(negedge clk) sample_stb = 1'b0;
            if (tx !== (done ? 1'b1 : mine[p])) hold_bad++;
            advance_stb = 1'b1;
            @(negedge clk) advance_stb = 1'b0;
        end
        other_bit = 1'b1;
        force_rec = 1'b0;
        check(tx_bad == 0, (ext ? "R4" : "R3"), {req, " tx sequence mismatches"}, tx_bad, 0);
        check(hold_bad == 0, "R5", {req, " tx not held between strobes"}, hold_bad, 0);
        check(arb_lost == e_lost, "R7", {req, " arb_lost"}, int'(arb_lost), int'(e_lost));
        if (e_lost) check(lost_pos == e_pos, "R7", {req, " lost_pos"}, int'(lost_pos), e_pos);
        check(bit_err == e_err, "R8", {req, " bit_err"}, int'(bit_err), int'(e_err));
        check(arb_won == !done, "R9", {req, " arb_won"}, int'(arb_won), int'(!done));
        check(tx == 1'b1, "R9", {req, " tx released after field"}, int'(tx), 1);
    endtask

    task automatic t_reset;
        check(tx == 1'b1 && !arb_won && !arb_lost && !bit_err, "R1", "reset state",
              {tx, arb_won, arb_lost, bit_err}, 8);
    endtask

    task automatic t_idle_strobes;
        for (int k = 0; k < 4; k++) begin
            other_bit = k[0];
            sample_stb = 1'b1; advance_stb = k[1];
            @(negedge clk) begin sample_stb = 1'b0; advance_stb = 1'b0; end
        end
        other_bit = 1'b1;
        check(tx == 1'b1 && !arb_won && !arb_lost && !bit_err, "R11", "strobes while idle",
              {tx, arb_won, arb_lost, bit_err}, 8);
    endtask

    task automatic t_alone;
        run_frame("R6 lone standard", 29'h555, 1'b0, 1'b0, '1, -1);
        run_frame("R6 lone extended", 29'h1ABC_DE5, 1'b1, 1'b1, '1, -1);
    endtask

    task automatic t_contend;
        run_frame("R12 higher id loses", 29'h123, 1'b0, 1'b0, ref_field(29'h120, 1'b0, 1'b0), -1);
        check(lost_pos == 6'd10, "R12", "loss at identifier bit 1", int'(lost_pos), 10);
        run_frame("R12 lower id wins", 29'h120, 1'b0, 1'b0, ref_field(29'h123, 1'b0, 1'b0), -1);
        run_frame("R4 extended vs standard", {11'h2A5, 18'h3FFFF}, 1'b1, 1'b0,
                  ref_field(29'h2A5, 1'b0, 1'b0), -1);
        check(lost_pos == 6'd12, "R4", "extended loses at substitute bit", int'(lost_pos), 12);
        run_frame("R3 remote vs data", 29'h0F0, 1'b0, 1'b1, ref_field(29'h0F0, 1'b0, 1'b0), -1);
        check(lost_pos == 6'd12, "R3", "remote loses on final bit", int'(lost_pos), 12);
        run_frame("R12 extended tie-break low bits", 29'h0000_101, 1'b1, 1'b0,
                  ref_field(29'h0000_100, 1'b1, 1'b0), -1);
    endtask

    task automatic t_bit_errors;
        run_frame("R8 start bit forced", 29'h7FF, 1'b0, 1'b0, '1, 0);
        run_frame("R8 mid field forced", 29'h000, 1'b0, 1'b0, '1, 5);
    endtask

    task automatic t_hold_and_clear;
        logic [5:0] held;
        run_frame("R10 setup loss", 29'h400, 1'b0, 1'b0, ref_field(29'h000, 1'b0, 1'b0), -1);
        held = lost_pos;
        for (int k = 0; k < 3; k++) begin
            other_bit = 1'b0;
            sample_stb = 1'b1; advance_stb = 1'b1;
            @(negedge clk) begin sample_stb = 1'b0; advance_stb = 1'b0; end
        end
        other_bit = 1'b1;
        check(arb_lost && lost_pos == held && tx, "R11", "strobes after loss ignored",
              int'(lost_pos), int'(held));
        check($countones({arb_won, arb_lost, bit_err}) == 1, "R10", "one flag only",
              $countones({arb_won, arb_lost, bit_err}), 1);
        @(negedge clk) sof_sync = 1'b1;
        @(negedge clk) sof_sync = 1'b0;
        check(!arb_won && !arb_lost && !bit_err && tx == 1'b0, "R10", "sync clears flags",
              {arb_won, arb_lost, bit_err}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_strobes();
        t_alone();
        t_contend();
        t_bit_errors();
        t_hold_and_clear();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule